// File: doc/BRIEF.md
# Dual-Copy Settings Record Selector

This block recovers a settings record from a byte-wide nonvolatile store that holds two redundant copies of it. It starts on a single-cycle pulse. It first fetches a 16-bit pointer from a fixed header location and turns it into a base address. It then reads both copies and checks each one with a CRC-16. A checked copy counts as usable only when its stored checksum matches the computed one.

When both copies are usable, the one with the larger update count wins. When only one is usable, that one is taken. The 112 payload bytes of the winning copy are then streamed, in order, to a destination buffer through a write strobe, a byte index and a data byte. A one-cycle completion pulse reports whether a record was delivered and which copy it came from. The memory read port is synchronous: data appears the cycle after the address is presented.

Top module: `settings_copy_select`

## Requirements
- R1: After a start pulse the first read is at address 0x20 (pointer low byte), the next at 0x21 (pointer high byte); the base address is that little-endian halfword shifted left by 3.
- R2: A base above 0x3FE00 ends the run with done high 4 cycles after the start edge, ok low, pick_second low and no output writes; a base of exactly 0x3FE00 is processed normally.
- R3: Copy 0 lies at the base and copy 1 at base+0x100; each copy's CRC covers its bytes 0x00..0x6F, starts at 0xFFFF, takes bits LSB first with the reflected polynomial 0xA001, and the copy is usable only if the result equals the little-endian checksum at copy bytes 0x72 (low) and 0x73 (high).
- R4: The update count is the little-endian halfword at copy bytes 0x70 (low) and 0x71 (high); with both copies usable, copy 1 is taken only if its count is strictly greater as a 16-bit unsigned number, so equal counts take copy 0.
- R5: With exactly one copy usable, that copy is taken; pick_second is 1 for copy 1 and 0 for copy 0.
- R6: With neither copy usable, done is raised with ok low and pick_second low and no output write occurs.
- R7: The taken copy's bytes 0x00..0x6F are written with out_idx running 0 to 111 in order, out_data equal to the stored byte, and at most one write in any two consecutive cycles.
- R8: The CRC advances one bit per clock (10 cycles per checked byte), so done arrives 2261 cycles after the start edge on a checksum failure and 2485 cycles after on success; busy is high from the cycle after the start edge until done.
- R9: done is high for exactly one cycle, and ok and pick_second keep their values until the next accepted start.
- R10: A start pulse while busy is ignored: the run in progress completes with unchanged results and timing.
- R11: After reset busy, done, ok, pick_second and out_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a selection run (ignored while busy) |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rdata | input | 8 | Memory data, valid one cycle after the request |
| busy | output | 1 | Run in progress |
| out_we | output | 1 | Destination write strobe |
| out_idx | output | IDX_W | Destination byte index |
| out_data | output | 8 | Destination write data |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | A record was delivered |
| pick_second | output | 1 | The delivered record came from copy 1 |

## Verification
Each result has a fixed latency counted from the clock edge that samples start. That latency is 4 cycles for an out-of-range base, 2261 for two failed checksums and 2485 for a delivered record, and every output write lands on a cycle of its own within the final 224 cycles. The bench drives inputs and samples outputs at the falling edge. It counts falling edges from the start edge and requires done at exactly the computed latency plus one. On every cycle in between it checks busy and compares any write against the next entry of a queue that its reference model built from the memory image.

// File: rtl/settings_copy_select_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the dual-copy settings record selector.
// Assumes a 16-bit reflected CRC; widths of the datapath come from the top.
package settings_copy_select_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PTR_LO,
        ST_PTR_HI,
        ST_PTR_CAP,
        ST_RANGE,
        ST_FETCH,
        ST_TAKE,
        ST_SHIFT,
        ST_DECIDE,
        ST_OUT_FETCH,
        ST_OUT_PUT
    } scs_state_e;

    localparam logic [15:0] SCS_CRC_SEED = 16'hFFFF;
    localparam logic [15:0] SCS_CRC_POLY = 16'hA001;

endpackage

// File: rtl/scs_crc_serial.sv
`timescale 1ns/1ps
// Bit-serial reflected CRC engine.
// init reloads the seed, load XORs a byte into the low bits, step shifts one
// bit (LSB first). Assumes the controller issues 8 steps after each load.
module scs_crc_serial #(
    parameter int          W    = 16,
    parameter logic [W-1:0] POLY = settings_copy_select_pkg::SCS_CRC_POLY,
    parameter logic [W-1:0] SEED = settings_copy_select_pkg::SCS_CRC_SEED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         load,
    input  logic [7:0]   byte_in,
    input  logic         step,
    output logic [W-1:0] crc
);
    logic [W-1:0] crc_q;

    // Remainder register: init has priority over load, load over step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= SEED;
        end else if (init) begin
            crc_q <= SEED;
        end else if (load) begin
            crc_q <= crc_q ^ {{(W-8){1'b0}}, byte_in};
        end else if (step) begin
            crc_q <= (crc_q >> 1) ^ (crc_q[0] ? POLY : '0);
        end
    end

    assign crc = crc_q;
endmodule

// File: rtl/scs_copy_judge.sv
`timescale 1ns/1ps
// Chooses between two record copies from their validity and update counts.
// Copy 1 wins only when it is valid and either copy 0 is invalid or its
// count is strictly larger. Purely combinational.
module scs_copy_judge #(
    parameter int CNT_W = 16
) (
    input  logic [1:0]       valid,
    input  logic [CNT_W-1:0] count0,
    input  logic [CNT_W-1:0] count1,
    output logic             any_valid,
    output logic             take_second
);
    // Arbitration between the two copies.
    always_comb begin
        any_valid   = valid[0] | valid[1];
        take_second = valid[1] & (~valid[0] | (count1 > count0));
    end
endmodule

// File: rtl/settings_copy_select.sv
`timescale 1ns/1ps
// Dual-copy settings record selector (top).
// Reads a pointer from the header, checks two record copies with a serial
// CRC, picks the newer valid copy and streams its payload out.
// Assumes a memory with one cycle of read latency and a start pulse.
module settings_copy_select #(
    parameter int ADDR_W      = 18,
    parameter int REC_LEN     = 112,
    parameter int PTR_ADDR    = 32,
    parameter int PTR_SHIFT   = 3,
    parameter int COPY_STRIDE = 256,
    parameter int BASE_LIMIT  = 32'h3FE00,
    localparam int IDX_W      = $clog2(REC_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              out_we,
    output logic [IDX_W-1:0]  out_idx,
    output logic [7:0]        out_data,
    output logic              done,
    output logic              ok,
    output logic              pick_second
);
    import settings_copy_select_pkg::*;

    localparam int POS_W  = $clog2(REC_LEN + 4);
    localparam int BASE_W = 16 + PTR_SHIFT;
    localparam logic [BASE_W-1:0] LIMIT_V   = BASE_W'(BASE_LIMIT);
    localparam logic [POS_W-1:0]  POS_CNTLO = POS_W'(REC_LEN);
    localparam logic [POS_W-1:0]  POS_CNTHI = POS_W'(REC_LEN + 1);
    localparam logic [POS_W-1:0]  POS_SUMLO = POS_W'(REC_LEN + 2);
    localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(REC_LEN + 3);
    localparam logic [POS_W-1:0]  POS_OUTND = POS_W'(REC_LEN - 1);

    scs_state_e        state_q;
    logic [7:0]        ptr_lo_q;
    logic [BASE_W-1:0] base_q;
    logic [POS_W-1:0]  pos_q;
    logic [2:0]        bit_q;
    logic              copy_q;
    logic [7:0]        cnt_lo_q;
    logic [7:0]        sum_lo_q;
    logic [15:0]       count_q [2];
    logic [1:0]        valid_q;
    logic              done_q, ok_q, pick_q;

    logic [15:0]       crc_val;
    logic              crc_init, crc_load, crc_step, crc_match;
    logic              any_valid, take_second;
    logic [ADDR_W-1:0] rec_addr;

    scs_crc_serial #(.W(16)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (crc_init),
        .load    (crc_load),
        .byte_in (mem_rdata),
        .step    (crc_step),
        .crc     (crc_val)
    );

    scs_copy_judge #(.CNT_W(16)) u_judge (
        .valid       (valid_q),
        .count0      (count_q[0]),
        .count1      (count_q[1]),
        .any_valid   (any_valid),
        .take_second (take_second)
    );

    // CRC engine control and checksum comparison.
    always_comb begin
        crc_init  = (state_q == ST_FETCH) && (pos_q == '0);
        crc_load  = (state_q == ST_TAKE) && (pos_q < POS_CNTLO);
        crc_step  = (state_q == ST_SHIFT);
        crc_match = ({mem_rdata, sum_lo_q} == crc_val);
    end

    // Memory address of the current byte within the current copy.
    always_comb begin
        rec_addr = ADDR_W'(base_q) + (copy_q ? ADDR_W'(COPY_STRIDE) : '0)
                 + ADDR_W'(pos_q);
        mem_rd_en = (state_q == ST_PTR_LO) || (state_q == ST_PTR_HI) ||
                    (state_q == ST_FETCH)  || (state_q == ST_OUT_FETCH);
        if (state_q == ST_PTR_LO)      mem_addr = ADDR_W'(PTR_ADDR);
        else if (state_q == ST_PTR_HI) mem_addr = ADDR_W'(PTR_ADDR + 1);
        else                           mem_addr = rec_addr;
    end

    // Sequencer: header, two checked copies, decision, payload delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ptr_lo_q <= '0;
            base_q   <= '0;
            pos_q    <= '0;
            bit_q    <= '0;
            copy_q   <= 1'b0;
            cnt_lo_q <= '0;
            sum_lo_q <= '0;
            count_q  <= '{default: '0};
            valid_q  <= '0;
            done_q   <= 1'b0;
            ok_q     <= 1'b0;
            pick_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    ok_q    <= 1'b0;
                    pick_q  <= 1'b0;
                    state_q <= ST_PTR_LO;
                end
                ST_PTR_LO: state_q <= ST_PTR_HI;
                ST_PTR_HI: begin
                    ptr_lo_q <= mem_rdata;
                    state_q  <= ST_PTR_CAP;
                end
                ST_PTR_CAP: begin
                    base_q  <= {mem_rdata, ptr_lo_q, {PTR_SHIFT{1'b0}}};
                    state_q <= ST_RANGE;
                end
                ST_RANGE: begin
                    if (base_q > LIMIT_V) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        copy_q  <= 1'b0;
                        pos_q   <= '0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: state_q <= ST_TAKE;
                ST_TAKE: begin
                    if (pos_q < POS_CNTLO) begin
                        bit_q   <= '0;
                        state_q <= ST_SHIFT;
                    end else begin
                        if (pos_q == POS_CNTLO)      cnt_lo_q <= mem_rdata;
                        else if (pos_q == POS_CNTHI) count_q[copy_q] <= {mem_rdata, cnt_lo_q};
                        else if (pos_q == POS_SUMLO) sum_lo_q <= mem_rdata;
                        else                         valid_q[copy_q] <= crc_match;
                        if (pos_q == POS_LAST) begin
                            pos_q <= '0;
                            if (copy_q) begin
                                state_q <= ST_DECIDE;
                            end else begin
                                copy_q  <= 1'b1;
                                state_q <= ST_FETCH;
                            end
                        end else begin
                            pos_q   <= pos_q + POS_W'(1);
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_SHIFT: begin
                    bit_q <= bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        pos_q   <= pos_q + POS_W'(1);
                        state_q <= ST_FETCH;
                    end
                end
                ST_DECIDE: begin
                    if (!any_valid) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        copy_q  <= take_second;
                        pick_q  <= take_second;
                        pos_q   <= '0;
                        state_q <= ST_OUT_FETCH;
                    end
                end
                ST_OUT_FETCH: state_q <= ST_OUT_PUT;
                ST_OUT_PUT: begin
                    if (pos_q == POS_OUTND) begin
                        ok_q    <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        pos_q   <= pos_q + POS_W'(1);
                        state_q <= ST_OUT_FETCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output drive.
    always_comb begin
        busy        = (state_q != ST_IDLE);
        out_we      = (state_q == ST_OUT_PUT);
        out_idx     = pos_q[IDX_W-1:0];
        out_data    = mem_rdata;
        done        = done_q;
        ok          = ok_q;
        pick_second = pick_q;
    end
endmodule

// File: rtl/settings_copy_select_chk.sv
`timescale 1ns/1ps
// Protocol checker for settings_copy_select, attached with bind.
// Observes ports only; assumes synchronous active-low reset.
module settings_copy_select_chk #(
    parameter int ADDR_W   = 18,
    parameter int IDX_W    = 7,
    parameter int PTR_ADDR = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              out_we,
    input logic [IDX_W-1:0]  out_idx,
    input logic              done
);
    // R1: a run opens with the pointer low-byte read.
    a_r1_first_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_rd_en && mem_addr == ADDR_W'(PTR_ADDR)));

    // R7: writes are separated by at least one idle cycle.
    a_r7_we_gap: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |=> !out_we);

    // R7: each non-first write follows the previous index by one.
    a_r7_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && out_idx != '0) |->
            ($past(out_we, 2) && out_idx == $past(out_idx, 2) + IDX_W'(1)));

    // R7: writes occur only inside a run.
    a_r7_we_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> busy);

    // R8: memory is read only inside a run.
    a_r8_rd_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> busy);

    // R8: completion is reported once the run has ended.
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: done is a single-cycle pulse.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind settings_copy_select settings_copy_select_chk #(
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .PTR_ADDR (PTR_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .out_we    (out_we),
    .out_idx   (out_idx),
    .done      (done)
);

// File: tb/settings_copy_select_tb_top.sv
`timescale 1ns/1ps
module settings_copy_select_tb_top;
    localparam int REC    = 112;
    localparam int ADDR_W = 18;
    localparam int LIMIT  = 32'h3FE00;
    localparam int LAT_RANGE = 4;
    localparam int LAT_CRC   = 5 + 2 * (10 * REC + 8);
    localparam int LAT_OK    = LAT_CRC + 2 * REC;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_rdata = 8'h00;
    logic              busy, out_we, done, ok, pick_second;
    logic [6:0]        out_idx;
    logic [7:0]        out_data;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] mem [int];
    int         exp_q [$];

    always #10 clk = ~clk;

    settings_copy_select dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .out_we(out_we), .out_idx(out_idx), .out_data(out_data),
        .done(done), .ok(ok), .pick_second(pick_second)
    );

    function automatic logic [7:0] peek(int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rdata <= peek(int'(mem_addr));

    task automatic check(bit cond, string req, string what, int act, int exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_of(int a);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < REC; i++) begin
            c ^= {8'h00, peek(a + i)};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
        end
        return c;
    endfunction

    task automatic put_copy(int a, int seed, logic [15:0] cnt, bit bad);
        logic [15:0] c;
        for (int i = 0; i < REC; i++) mem[a + i] = 8'((i * 37 + seed * 11 + (i >> 3) * 5) & 8'hFF);
        c = crc_of(a) ^ (bad ? 16'h0100 : 16'h0000);
        mem[a + 8'h70] = cnt[7:0];
        mem[a + 8'h71] = cnt[15:8];
        mem[a + 8'h72] = c[7:0];
        mem[a + 8'h73] = c[15:8];
    endtask

    task automatic prep(logic [15:0] ptr, int s0, int s1, logic [15:0] c0, logic [15:0] c1,
                        bit bad0, bit bad1);
        int base;
        mem.delete();
        mem[32] = ptr[7:0];
        mem[33] = ptr[15:8];
        base = int'(ptr) << 3;
        if (base <= LIMIT) begin
            put_copy(base, s0, c0, bad0);
            put_copy(base + 256, s1, c1, bad1);
        end
    endtask

    // Reference model plus cycle-by-cycle comparison for one run.
    task automatic run(string req, bit poke_start);
        int base, lat, n, a;
        bit v0, v1, e_ok, e_sel, seen;
        logic [15:0] k0, k1;
        exp_q.delete();
        base = int'({peek(33), peek(32)}) << 3;
        e_ok = 0; e_sel = 0;
        if (base > LIMIT) begin
            lat = LAT_RANGE;
        end else begin
            v0 = (crc_of(base) == {peek(base + 8'h73), peek(base + 8'h72)});
            v1 = (crc_of(base + 256) == {peek(base + 256 + 8'h73), peek(base + 256 + 8'h72)});
            k0 = {peek(base + 8'h71), peek(base + 8'h70)};
            k1 = {peek(base + 256 + 8'h71), peek(base + 256 + 8'h70)};
            if (!v0 && !v1) lat = LAT_CRC;
            else begin
                lat = LAT_OK; e_ok = 1;
                e_sel = v1 && (!v0 || k1 > k0);
                a = base + (e_sel ? 256 : 0);
                for (int i = 0; i < REC; i++) exp_q.push_back((i << 8) | int'(peek(a + i)));
            end
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 1; seen = 0;
        while (n < 3000) begin
            if (done) begin seen = 1; break; end
            check(busy == 1'b1, req, "R8 busy during run", busy, 1);
            if (out_we) begin
                if (exp_q.size() == 0) check(1'b0, req, "R6/R7 unexpected write idx", int'(out_idx), -1);
                else begin
                    a = exp_q.pop_front();
                    check(int'(out_idx) == (a >> 8), req, "R7 write index", int'(out_idx), a >> 8);
                    check(int'(out_data) == (a & 255), req, "R7 write data", int'(out_data), a & 255);
                end
            end
            start = (poke_start && (n == 50 || n == 2300)) ? 1'b1 : 1'b0;
            @(negedge clk); n++;
        end
        start = 1'b0;
        check(seen, req, "R8 done seen", int'(seen), 1);
        check(n == lat + 1, req, "R8 done latency", n - 1, lat);
        check(ok == e_ok, req, "ok", ok, e_ok);
        check(pick_second == e_sel, req, "pick_second", pick_second, e_sel);
        check(exp_q.size() == 0, req, "R7 writes remaining", exp_q.size(), 0);
        check(busy == 1'b0, req, "R8 busy at done", busy, 0);
        @(negedge clk);
        check(done == 1'b0, req, "R9 done pulse width", done, 0);
        check(ok == e_ok && pick_second == e_sel, req, "R9 status held",
              {ok, pick_second}, {e_ok, e_sel});
    endtask

    initial begin
        #(200000 * 20);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check({busy, done, ok, pick_second, out_we} == 5'b0, "R11", "reset outputs",
              {busy, done, ok, pick_second, out_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R4: little-endian pointer 0x0321, both valid, copy 0 newer
        prep(16'h0321, 1, 2, 16'h0040, 16'h0010, 0, 0); run("R1_R4_first_newer", 0);
        // R4: copy 1 newer
        prep(16'h0200, 3, 4, 16'h0005, 16'h0006, 0, 0); run("R4_second_newer", 0);
        // R4: equal counts take copy 0
        prep(16'h0200, 5, 6, 16'h1234, 16'h1234, 0, 0); run("R4_equal_counts", 0);
        // R4: unsigned compare, 0xFFFF beats 0x0001
        prep(16'h0480, 7, 8, 16'h0001, 16'hFFFF, 0, 0); run("R4_unsigned", 0);
        // R3 R5: only copy 1 valid
        prep(16'h0200, 9, 10, 16'h0900, 16'h0001, 1, 0); run("R3_R5_only_second", 0);
        // R5: only copy 0 valid
        prep(16'h0200, 11, 12, 16'h0001, 16'h0900, 0, 1); run("R5_only_first", 0);
        // R6: neither valid
        prep(16'h0200, 13, 14, 16'h0001, 16'h0002, 1, 1); run("R6_none_valid", 0);
        // R2: base one step above the limit
        prep(16'h7FC1, 0, 0, 16'h0, 16'h0, 0, 0); run("R2_over_limit", 0);
        // R2: base exactly at the limit
        prep(16'h7FC0, 15, 16, 16'h0002, 16'h0003, 0, 0); run("R2_at_limit", 0);
        // R10: start pulses during a run are ignored
        prep(16'h0321, 17, 18, 16'h0002, 16'h0001, 0, 0); run("R10_start_ignored", 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule